// File: doc/BRIEF.md
# Floating-Point / Integer Register Bit-Move Unit

This unit decodes and executes the raw bit-move instructions that carry a value between the floating-point/vector register file and the general-purpose register file. The value is not converted numerically. Each accepted instruction arrives as a set of fields on one cycle with `valid_i`. The fields are a size bit, a reserved S bit, a 2-bit type, a 2-bit mode, a 3-bit opcode and two 5-bit register numbers. From them the unit works out the integer width, the floating-point width, the transfer direction and which 64-bit half of the vector register is used. It then applies the legality rules in a fixed order.

The register files sit outside the block. The unit drives their read addresses combinationally from the incoming fields and takes the read data back in the same cycle. One clock later it presents a registered result: a general-register write, or a vector-register write with byte enables, together with a done strobe and, where the encoding is rejected, one error flag. The program counter is held inside the unit. It advances by a fixed step only when a move completes.

Top module: `fpint_move_unit`

## Requirements
- R1: The integer width is 32 bits when the size bit is 0 and 64 bits when it is 1. A 32-bit integer result is written with bits 63:32 cleared.
- R2: The floating-point width depends on the type field. Type 00 gives 32 bits, 01 and 10 give 64 bits, and 11 gives 16 bits.
- R3: Let the selector be {opcode[2:1], mode}. An encoding that escapes R4 is flagged unimplemented (err_unimpl_o) unless S=0, mode[1]=0 and opcode[2:1]=11.
- R4: Type 10 with any selector other than 1101 is flagged illegal. This rule takes priority over R3.
- R5: Selector 1100 uses the lower half, at offset 0. It is illegal unless the floating-point width is 16 or equals the integer width.
- R6: Selector 1101 uses the upper 64-bit half, at bit offset 64. It is illegal unless the integer width is 64 and the type is 10.
- R7: With opcode[0]=0 (float to integer), the unit reads the vector register numbered Rn. It takes the floating-point-width field at offset part×64, zero-extends it, and writes it to general register Rd.
- R8: With opcode[0]=1 (integer to float), the unit takes the low floating-point-width bits of general register Rn and writes them into vector register Rd at the selected part. The byte enables cover exactly those bytes, and all bytes outside the enables are zero.
- R9: A completed move advances pc_o by 4, which starts from its reset value. A rejected encoding leaves pc_o unchanged and causes no register write.
- R10: Each valid instruction produces a one-cycle done_o on the next cycle. At most one of err_illegal_o, err_unimpl_o and a register write is active with it.
- R11: A cycle without valid_i produces no done, no error, no write and no PC change on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | Instruction fields are valid this cycle |
| sf_i | input | 1 | Size bit (integer width select) |
| s_i | input | 1 | Reserved S bit |
| ftype_i | input | 2 | Floating-point type field |
| rmode_i | input | 2 | Mode field |
| opcode_i | input | 3 | Opcode field |
| rn_i | input | GPR_AW | Source register number |
| rd_i | input | GPR_AW | Destination register number |
| gpr_raddr_o | output | GPR_AW | General register read address |
| gpr_rdata_i | input | 64 | General register read data |
| vreg_raddr_o | output | VREG_AW | Vector register read address |
| vreg_rpart_o | output | 1 | Vector read half select |
| vreg_rdata_i | input | 128 | Vector register read data |
| gpr_we_o | output | 1 | General register write enable |
| gpr_waddr_o | output | GPR_AW | General register write address |
| gpr_wdata_o | output | 64 | General register write data |
| vreg_we_o | output | 1 | Vector register write enable |
| vreg_waddr_o | output | VREG_AW | Vector register write address |
| vreg_wpart_o | output | 1 | Vector write half select |
| vreg_wbe_o | output | 16 | Vector write byte enables |
| vreg_wdata_o | output | 128 | Vector write data, already placed at its offset |
| done_o | output | 1 | One-cycle completion strobe |
| err_illegal_o | output | 1 | Illegal encoding flag |
| err_unimpl_o | output | 1 | Unimplemented encoding flag |
| pc_o | output | PC_W | Program counter |

## Verification
The bench builds the unit with its default 5-bit register numbers and 64-bit PC, and overrides the reset PC to 0x400 so that a stuck-at-zero counter shows up. That configuration leaves only 512 combinations of size, S, type, mode and opcode. The bench therefore sweeps all of them twice, with different register numbers and read-data patterns, and reaches every legality branch, both halves and every width pairing. Each instruction is followed by an idle cycle, so the no-effect rule is checked after every kind of preceding operation.

// File: rtl/fpint_move_pkg.sv
package fpint_move_pkg;

    localparam int XLEN   = 64;
    localparam int VLEN   = 2 * XLEN;
    localparam int VBYTES = VLEN / 8;
    localparam int WW     = 7;   // holds a width or offset up to 64

    typedef enum logic [1:0] {
        MV_NONE = 2'd0,
        MV_F2I  = 2'd1,
        MV_I2F  = 2'd2
    } mv_dir_e;

    typedef struct packed {
        logic          legal;
        logic          err_ill;
        logic          err_unimp;
        mv_dir_e       dir;
        logic          part;
        logic [WW-1:0] int_w;
        logic [WW-1:0] flt_w;
    } mv_dec_t;

    function automatic logic [XLEN-1:0] low_mask(input logic [WW-1:0] w);
        logic [XLEN-1:0] m;
        for (int i = 0; i < XLEN; i++) m[i] = (i < int'(w));
        return m;
    endfunction

endpackage

// File: rtl/fpint_move_decode.sv
module fpint_move_decode
    import fpint_move_pkg::*;
(
    input  logic       sf_i,
    input  logic       s_i,
    input  logic [1:0] ftype_i,
    input  logic [1:0] rmode_i,
    input  logic [2:0] opcode_i,
    output mv_dec_t    dec_o
);

    logic [3:0] sel;
    logic       claimed;

    always_comb begin
        sel     = {opcode_i[2:1], rmode_i};
        claimed = !s_i && !rmode_i[1] && (opcode_i[2:1] == 2'b11);

        dec_o           = '0;
        dec_o.int_w     = sf_i ? WW'(64) : WW'(32);
        if (ftype_i == 2'b10) dec_o.flt_w = WW'(64);
        else                  dec_o.flt_w = WW'(8 << (ftype_i ^ 2'b10));
        dec_o.part      = rmode_i[0];

        if (ftype_i == 2'b10 && sel != 4'b1101) begin
            dec_o.err_ill = 1'b1;
        end else if (!claimed) begin
            dec_o.err_unimp = 1'b1;
        end else if (!rmode_i[0]) begin
            dec_o.err_ill = !(dec_o.flt_w == WW'(16) || dec_o.flt_w == dec_o.int_w);
        end else begin
            dec_o.err_ill = !(dec_o.int_w == WW'(64) && ftype_i == 2'b10);
        end

        dec_o.legal = !dec_o.err_ill && !dec_o.err_unimp;
        if (dec_o.legal) dec_o.dir = opcode_i[0] ? MV_I2F : MV_F2I;
        else             dec_o.dir = MV_NONE;
    end

endmodule

// File: rtl/fpint_move_path.sv
module fpint_move_path
    import fpint_move_pkg::*;
(
    input  mv_dec_t           dec_i,
    input  logic [XLEN-1:0]   gpr_rdata_i,
    input  logic [VLEN-1:0]   vreg_rdata_i,
    output logic [XLEN-1:0]   gpr_wdata_o,
    output logic [VLEN-1:0]   vreg_wdata_o,
    output logic [VBYTES-1:0] vreg_wbe_o
);

    logic [WW-1:0]   off;
    logic [VLEN-1:0] shifted;
    logic [XLEN-1:0] int_field;

    always_comb begin
        off       = dec_i.part ? WW'(XLEN) : WW'(0);
        shifted   = vreg_rdata_i >> off;
        gpr_wdata_o = shifted[XLEN-1:0] & low_mask(dec_i.flt_w);

        int_field    = gpr_rdata_i & low_mask(dec_i.int_w) & low_mask(dec_i.flt_w);
        vreg_wdata_o = {{XLEN{1'b0}}, int_field} << off;
    end

    for (genvar b = 0; b < VBYTES; b++) begin : g_be
        assign vreg_wbe_o[b] = (b * 8 >= int'(off)) && (b * 8 < int'(off) + int'(dec_i.flt_w));
    end

endmodule

// File: rtl/fpint_move_unit.sv
module fpint_move_unit
    import fpint_move_pkg::*;
#(
    parameter int            GPR_AW   = 5,
    parameter int            VREG_AW  = 5,
    parameter int            PC_W     = 64,
    parameter int            PC_STEP  = 4,
    parameter logic [63:0]   PC_RESET = 64'h0
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               valid_i,
    input  logic               sf_i,
    input  logic               s_i,
    input  logic [1:0]         ftype_i,
    input  logic [1:0]         rmode_i,
    input  logic [2:0]         opcode_i,
    input  logic [GPR_AW-1:0]  rn_i,
    input  logic [GPR_AW-1:0]  rd_i,
    output logic [GPR_AW-1:0]  gpr_raddr_o,
    input  logic [63:0]        gpr_rdata_i,
    output logic [VREG_AW-1:0] vreg_raddr_o,
    output logic               vreg_rpart_o,
    input  logic [127:0]       vreg_rdata_i,
    output logic               gpr_we_o,
    output logic [GPR_AW-1:0]  gpr_waddr_o,
    output logic [63:0]        gpr_wdata_o,
    output logic               vreg_we_o,
    output logic [VREG_AW-1:0] vreg_waddr_o,
    output logic               vreg_wpart_o,
    output logic [15:0]        vreg_wbe_o,
    output logic [127:0]       vreg_wdata_o,
    output logic               done_o,
    output logic               err_illegal_o,
    output logic               err_unimpl_o,
    output logic [PC_W-1:0]    pc_o
);

    typedef struct packed {
        logic                done;
        logic                err_ill;
        logic                err_unimp;
        logic                gpr_we;
        logic [GPR_AW-1:0]   gpr_waddr;
        logic [XLEN-1:0]     gpr_wdata;
        logic                vreg_we;
        logic [VREG_AW-1:0]  vreg_waddr;
        logic                vreg_wpart;
        logic [VBYTES-1:0]   vreg_wbe;
        logic [VLEN-1:0]     vreg_wdata;
        logic [PC_W-1:0]     pc;
    } unit_state_t;

    mv_dec_t           dec;
    logic [XLEN-1:0]   f2i_data;
    logic [VLEN-1:0]   i2f_data;
    logic [VBYTES-1:0] i2f_be;
    unit_state_t       st_d, st_q;

    fpint_move_decode decode_i (
        .sf_i     (sf_i),
        .s_i      (s_i),
        .ftype_i  (ftype_i),
        .rmode_i  (rmode_i),
        .opcode_i (opcode_i),
        .dec_o    (dec)
    );

    fpint_move_path path_i (
        .dec_i        (dec),
        .gpr_rdata_i  (gpr_rdata_i),
        .vreg_rdata_i (vreg_rdata_i),
        .gpr_wdata_o  (f2i_data),
        .vreg_wdata_o (i2f_data),
        .vreg_wbe_o   (i2f_be)
    );

    assign gpr_raddr_o  = rn_i;
    assign vreg_raddr_o = VREG_AW'(rn_i);
    assign vreg_rpart_o = dec.part;

    always_comb begin
        st_d    = '0;
        st_d.pc = st_q.pc;
        if (valid_i) begin
            st_d.done      = 1'b1;
            st_d.err_ill   = dec.err_ill;
            st_d.err_unimp = dec.err_unimp;
            if (dec.legal) begin
                st_d.pc = st_q.pc + PC_W'(PC_STEP);
                if (dec.dir == MV_F2I) begin
                    st_d.gpr_we    = 1'b1;
                    st_d.gpr_waddr = rd_i;
                    st_d.gpr_wdata = f2i_data;
                end else begin
                    st_d.vreg_we    = 1'b1;
                    st_d.vreg_waddr = VREG_AW'(rd_i);
                    st_d.vreg_wpart = dec.part;
                    st_d.vreg_wbe   = i2f_be;
                    st_d.vreg_wdata = i2f_data;
                end
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q    <= '0;
            st_q.pc <= PC_RESET[PC_W-1:0];
        end else begin
            st_q <= st_d;
        end
    end

    assign gpr_we_o      = st_q.gpr_we;
    assign gpr_waddr_o   = st_q.gpr_waddr;
    assign gpr_wdata_o   = st_q.gpr_wdata;
    assign vreg_we_o     = st_q.vreg_we;
    assign vreg_waddr_o  = st_q.vreg_waddr;
    assign vreg_wpart_o  = st_q.vreg_wpart;
    assign vreg_wbe_o    = st_q.vreg_wbe;
    assign vreg_wdata_o  = st_q.vreg_wdata;
    assign done_o        = st_q.done;
    assign err_illegal_o = st_q.err_ill;
    assign err_unimpl_o  = st_q.err_unimp;
    assign pc_o          = st_q.pc;

endmodule

// File: rtl/fpint_move_checker.sv
module fpint_move_checker #(
    parameter int PC_W    = 64,
    parameter int PC_STEP = 4
) (
    input logic            clk_i,
    input logic            rst_ni,
    input logic            valid_i,
    input logic            done_o,
    input logic            err_illegal_o,
    input logic            err_unimpl_o,
    input logic            gpr_we_o,
    input logic            vreg_we_o,
    input logic [15:0]     vreg_wbe_o,
    input logic [PC_W-1:0] pc_o
);

    AST_OUTCOME_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({err_illegal_o, err_unimpl_o, gpr_we_o, vreg_we_o})) else $error("onehot"); // R10

    AST_OUTCOME_NEEDS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (err_illegal_o || err_unimpl_o || gpr_we_o || vreg_we_o) |-> done_o) else $error("done"); // R10

    AST_PC_HOLD_ON_ERROR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (err_illegal_o || err_unimpl_o) |-> pc_o == $past(pc_o)) else $error("pc hold"); // R9

    AST_PC_STEP_ON_MOVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (gpr_we_o || vreg_we_o) |-> pc_o == $past(pc_o) + PC_W'(PC_STEP)) else $error("pc step"); // R9

    AST_IDLE_NO_EFFECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$past(valid_i) |-> (!done_o && pc_o == $past(pc_o))) else $error("idle"); // R11

    AST_WBE_SIZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        vreg_we_o |-> ($countones(vreg_wbe_o) == 2 || $countones(vreg_wbe_o) == 4 ||
                       $countones(vreg_wbe_o) == 8)) else $error("wbe"); // R8

endmodule

bind fpint_move_unit fpint_move_checker #(.PC_W(PC_W), .PC_STEP(PC_STEP)) chk_i (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .valid_i       (valid_i),
    .done_o        (done_o),
    .err_illegal_o (err_illegal_o),
    .err_unimpl_o  (err_unimpl_o),
    .gpr_we_o      (gpr_we_o),
    .vreg_we_o     (vreg_we_o),
    .vreg_wbe_o    (vreg_wbe_o),
    .pc_o          (pc_o)
);

// File: tb/fpint_move_unit_tb_top.sv
module fpint_move_unit_tb_top;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         valid;
    logic         sf, sb;
    logic [1:0]   ftype, rmode;
    logic [2:0]   opcode;
    logic [4:0]   rn, rd;
    logic [4:0]   gpr_raddr, vreg_raddr, gpr_waddr, vreg_waddr;
    logic         vreg_rpart, vreg_wpart;
    logic [63:0]  gpr_rdata, gpr_wdata;
    logic [127:0] vreg_rdata, vreg_wdata;
    logic         gpr_we, vreg_we, done, err_ill, err_unimp;
    logic [15:0]  vreg_wbe;
    logic [63:0]  pc;
    logic [31:0]  seed;

    int errors = 0;
    int checks = 0;
    bit finished = 0;
    logic [63:0] exp_pc;

    always #5 clk = ~clk;

    fpint_move_unit #(.PC_RESET(64'h400)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .sf_i(sf), .s_i(sb),
        .ftype_i(ftype), .rmode_i(rmode), .opcode_i(opcode), .rn_i(rn), .rd_i(rd),
        .gpr_raddr_o(gpr_raddr), .gpr_rdata_i(gpr_rdata),
        .vreg_raddr_o(vreg_raddr), .vreg_rpart_o(vreg_rpart), .vreg_rdata_i(vreg_rdata),
        .gpr_we_o(gpr_we), .gpr_waddr_o(gpr_waddr), .gpr_wdata_o(gpr_wdata),
        .vreg_we_o(vreg_we), .vreg_waddr_o(vreg_waddr), .vreg_wpart_o(vreg_wpart),
        .vreg_wbe_o(vreg_wbe), .vreg_wdata_o(vreg_wdata),
        .done_o(done), .err_illegal_o(err_ill), .err_unimpl_o(err_unimp), .pc_o(pc)
    );

    function automatic logic [63:0] gpr_pat(input logic [4:0] a, input logic [31:0] s);
        return {s ^ 32'h9E37_79B9, ~s ^ {27'd0, a}};
    endfunction

    function automatic logic [127:0] vreg_pat(input logic [4:0] a, input logic [31:0] s);
        return {32'(s * 3 + {27'd0, a}), s ^ 32'hDEAD_0000 ^ {27'd0, a}, ~s, 32'(s + {27'd0, a} * 7)};
    endfunction

    always_comb gpr_rdata  = gpr_pat(gpr_raddr, seed);
    always_comb vreg_rdata = vreg_pat(vreg_raddr, seed);

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    task automatic run_one(input logic [8:0] enc, input int pass);
        int          intw, fltw, off;
        logic [3:0]  sel;
        logic        e_ill, e_unimp, ok;
        string       rule;
        logic [63:0] imask, fmask, gval;
        logic [127:0] vval, e_vdata;
        logic [15:0] e_be;
        logic [4:0]  rn_v, rd_v;
        logic [31:0] sd;

        rn_v = 5'((int'(enc) * 7 + pass) % 32);
        rd_v = 5'((int'(enc) * 11 + 3 * pass) % 32);
        sd   = 32'(int'(enc) * 32'h0100_0193 + pass * 32'h1357_9BDF);

        @(negedge clk);
        valid = 1'b1; sf = enc[8]; sb = enc[7]; ftype = enc[6:5]; rmode = enc[4:3];
        opcode = enc[2:0]; rn = rn_v; rd = rd_v; seed = sd;

        // Expected values per the requirements
        intw = enc[8] ? 64 : 32;                                           // R1
        fltw = (enc[6:5] == 2'b10) ? 64 : (8 << (enc[6:5] ^ 2'b10));      // R2
        sel  = {enc[2:1], enc[4:3]};
        e_ill = 0; e_unimp = 0; rule = "R4";
        if (enc[6:5] == 2'b10 && sel != 4'b1101) begin e_ill = 1; rule = "R4"; end
        else if (!(enc[7] == 0 && enc[4] == 0 && enc[2:1] == 2'b11)) begin e_unimp = 1; rule = "R3"; end
        else if (enc[3] == 0) begin e_ill = !(fltw == 16 || fltw == intw); rule = "R5"; end
        else begin e_ill = !(intw == 64 && enc[6:5] == 2'b10); rule = "R6"; end
        ok  = !e_ill && !e_unimp;
        off = enc[3] ? 64 : 0;
        imask = (intw == 64) ? '1 : 64'hFFFF_FFFF;
        fmask = (fltw == 64) ? '1 : ((64'd1 << fltw) - 1);
        vval  = vreg_pat(rn_v, sd);
        gval  = gpr_pat(rn_v, sd);
        e_vdata = {64'd0, gval & imask & fmask} << off;
        e_be  = 16'(((32'd1 << (fltw / 8)) - 1) << (off / 8));

        @(posedge clk); #1;
        check("R10 done strobe", {127'd0, done}, 128'd1);
        check({rule, " illegal flag"}, {127'd0, err_ill}, {127'd0, e_ill});
        check("R3 unimplemented flag", {127'd0, err_unimp}, {127'd0, e_unimp});
        check("R7 gpr write enable", {127'd0, gpr_we}, {127'd0, ok && !enc[0]});
        check("R8 vreg write enable", {127'd0, vreg_we}, {127'd0, ok && enc[0]});
        if (ok) exp_pc = exp_pc + 64'd4;
        check("R9 pc", {64'd0, pc}, {64'd0, exp_pc});
        if (ok && !enc[0]) begin
            check("R7 gpr waddr", {123'd0, gpr_waddr}, {123'd0, rd_v});
            check("R7 R1 R2 gpr data", {64'd0, gpr_wdata}, {64'd0, 64'(vval >> off) & fmask});
        end
        if (ok && enc[0]) begin
            check("R8 vreg waddr", {123'd0, vreg_waddr}, {123'd0, rd_v});
            check("R8 R6 vreg part", {127'd0, vreg_wpart}, {127'd0, enc[3]});
            check("R8 R2 byte enables", {112'd0, vreg_wbe}, {112'd0, e_be});
            check("R8 R1 vreg data", vreg_wdata, e_vdata);
        end

        @(negedge clk);
        valid = 1'b0; sf = ~sf; opcode = 3'b111; rmode = 2'b00; sb = 1'b0;
        @(posedge clk); #1;
        check("R11 idle done", {127'd0, done}, 128'd0);
        check("R11 idle writes", {126'd0, gpr_we, vreg_we}, 128'd0);
        check("R11 idle errors", {126'd0, err_ill, err_unimp}, 128'd0);
        check("R11 idle pc", {64'd0, pc}, {64'd0, exp_pc});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog expired act=running exp=finished");
            finish_run();
        end
    end

    initial begin
        rst_n = 1'b0; valid = 1'b0; sf = 0; sb = 0; ftype = 0; rmode = 0;
        opcode = 0; rn = 0; rd = 0; seed = 0;
        exp_pc = 64'h400;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        check("R9 reset pc", {64'd0, pc}, {64'd0, 64'h400});
        check("R10 reset done", {124'd0, done, err_ill, err_unimp, gpr_we}, 128'd0);
        check("R10 reset vreg we", {127'd0, vreg_we}, 128'd0);
        for (int pass = 0; pass < 2; pass++) begin
            for (int e = 0; e < 512; e++) begin
                run_one(9'(e), pass);
            end
        end
        finish_run();
    end

endmodule